// File: doc/BRIEF.md
# User-Level Block Send Engine

This block lets an unprivileged process copy a contiguous block of local memory into a buffer on a remote node. No kernel call is involved. The process makes two writes to dedicated command addresses. The first write, called the arm access, holds the remote destination address and the byte count. The second write, called the fire access, holds the local source address and starts the copy.

Once fired, the engine reads local memory one word at a time through a read port with a fixed one-cycle latency. It sends the data out on a valid/ready stream. The data is cut into packets, and each packet starts with a header beat that gives the running destination address and the payload size. Three flags report status: busy, done and a sticky error bit.

Only one command can be outstanding. Command accesses made while a copy is running are refused, so copies never overlap and leave the node in the order they were issued. Nothing orders this traffic against other outgoing traffic that the node produces.

Top module: `ubx_send_engine`

## Requirements
- R1: After reset, busy, done, err, out_valid and mem_rd_en are all 0.
- R2: An arm access (cmd_we=1, cmd_fire=0) records cmd_addr as the destination and cmd_len as the byte count. A following fire access (cmd_we=1, cmd_fire=1) records cmd_addr as the source and starts the copy, so busy is 1 from the clock edge that takes the fire. The low three bits of both addresses and of the length are dropped, so copies are whole 8-byte words.
- R3: Payload words are read from consecutive word addresses, starting at the source, and are sent in that order.
- R4: Each packet is one header beat (out_sop=1) followed by 1 to 8 payload beats (at most 64 bytes). The header word holds the payload byte count in bits [63:32] and the destination address in bits [31:0]. out_last marks the final payload beat of each packet.
- R5: The destination in each header equals the armed destination plus the number of bytes already sent in earlier packets.
- R6: A fire access with no recorded arm is ignored and sets err. Each fire uses up its arm, so a second fire needs a new arm. An accepted arm access clears err.
- R7: While busy is 1, arm and fire accesses are ignored (no new copy starts and no arm is recorded) and set err.
- R8: A fire with a zero word count sends no beats. busy stays 0 and done is 1 after the fire's clock edge.
- R9: done rises and busy falls at the clock edge that accepts the last payload beat. done clears at the edge of the next accepted fire.
- R10: While out_valid is 1 and out_ready is 0, out_valid and out_data stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_we | input | 1 | Command access strobe |
| cmd_fire | input | 1 | 0 = arm access, 1 = fire access |
| cmd_addr | input | 32 | Destination (arm) or source (fire) byte address |
| cmd_len | input | 16 | Byte count (arm only) |
| busy | output | 1 | Copy in progress |
| done | output | 1 | Last copy finished |
| err | output | 1 | Sticky refused-access flag |
| mem_rd_en | output | 1 | Local memory read request |
| mem_rd_addr | output | 32 | Read byte address |
| mem_rd_data | input | 64 | Read data, valid one cycle after the request |
| out_valid | output | 1 | Outgoing beat valid |
| out_ready | input | 1 | Downstream accepts the beat |
| out_sop | output | 1 | Beat is a packet header |
| out_last | output | 1 | Final payload beat of a packet |
| out_data | output | 64 | Header or payload word |

## Verification
- **Command accesses:** each access takes effect at the clock edge that samples it. busy, err and an immediate done for a zero-length copy are therefore sampled on the falling edge right after that edge.
- **Unstalled copy:** a header appears one cycle after the fire. Each payload beat takes three cycles: the read, the capture and the send.
- **Finish:** done is checked low on the falling edge where the final beat is offered, and high one falling edge later.
- **Sampling:** inputs change just after the rising edge, and outputs are sampled on the falling edge. Each handshake is recorded in the cycle it completes.

// File: rtl/ubx_pkg.sv
package ubx_pkg;

    localparam int UBX_ADDR_W = 32;
    localparam int UBX_LEN_W  = 16;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_HDR  = 3'd1,
        ST_RD   = 3'd2,
        ST_CAP  = 3'd3,
        ST_DATA = 3'd4
    } mover_st_e;

    typedef struct packed {
        logic [UBX_ADDR_W-1:0] src;
        logic [UBX_ADDR_W-1:0] dst;
        logic [UBX_LEN_W-1:0]  len;
    } xfer_cmd_t;

    function automatic logic [UBX_ADDR_W-1:0] word_align(
        input logic [UBX_ADDR_W-1:0] a, input int sh);
        logic [UBX_ADDR_W-1:0] m;
        m = '1;
        m = m << sh;
        return a & m;
    endfunction

endpackage

// File: rtl/ubx_cmd_port.sv
module ubx_cmd_port
    import ubx_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cmd_we,
    input  logic                  cmd_fire,
    input  logic [UBX_ADDR_W-1:0] cmd_addr,
    input  logic [UBX_LEN_W-1:0]  cmd_len,
    input  logic                  busy,
    output logic                  start,
    output xfer_cmd_t             cmd,
    output logic                  err
);

    logic                  armed_q;
    logic [UBX_ADDR_W-1:0] dst_q;
    logic [UBX_LEN_W-1:0]  len_q;

    assign start = cmd_we && cmd_fire && !busy && armed_q;

    always_comb begin
        cmd.src = cmd_addr;
        cmd.dst = dst_q;
        cmd.len = len_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
            dst_q   <= '0;
            len_q   <= '0;
            err     <= 1'b0;
        end else if (cmd_we) begin
            if (busy) begin
                err <= 1'b1;
            end else if (!cmd_fire) begin
                armed_q <= 1'b1;
                dst_q   <= cmd_addr;
                len_q   <= cmd_len;
                err     <= 1'b0;
            end else if (armed_q) begin
                armed_q <= 1'b0;
            end else begin
                err <= 1'b1;
            end
        end
    end

    AST_ORPHAN_FIRE_ERR: assert property (@(posedge clk) disable iff (rst)
        (cmd_we && cmd_fire && !armed_q && !busy) |=> (err && !start)) else $error("orphan fire"); // R6

    AST_BUSY_ACCESS_ERR: assert property (@(posedge clk) disable iff (rst)
        (cmd_we && busy) |=> err) else $error("busy access"); // R7

endmodule

// File: rtl/ubx_mover.sv
module ubx_mover
    import ubx_pkg::*;
#(
    parameter int DATA_W    = 64,
    parameter int PKT_BYTES = 64
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  xfer_cmd_t             cmd,
    output logic                  busy,
    output logic                  done,
    output logic                  mem_rd_en,
    output logic [UBX_ADDR_W-1:0] mem_rd_addr,
    input  logic [DATA_W-1:0]     mem_rd_data,
    output logic                  out_valid,
    input  logic                  out_ready,
    output logic                  out_sop,
    output logic                  out_last,
    output logic [DATA_W-1:0]     out_data
);

    localparam int WB        = DATA_W / 8;
    localparam int SH        = $clog2(WB);
    localparam int PKT_WORDS = PKT_BYTES / WB;
    localparam int PW        = $clog2(PKT_WORDS + 1);
    localparam int HL        = DATA_W - UBX_ADDR_W;

    mover_st_e             st;
    logic [UBX_ADDR_W-1:0] src_q, dst_q;
    logic [UBX_LEN_W-1:0]  rem_q;
    logic [PW-1:0]         pkt_left_q, pkt_words;
    logic [DATA_W-1:0]     data_q;
    logic [UBX_LEN_W-1:0]  start_words;
    logic [HL-1:0]         hdr_bytes;

    assign start_words = cmd.len >> SH;

    always_comb begin
        if (rem_q > UBX_LEN_W'(PKT_WORDS)) pkt_words = PW'(PKT_WORDS);
        else                               pkt_words = PW'(rem_q);
    end

    generate
        if (HL >= PW + SH) begin : g_hdr_wide
            assign hdr_bytes = HL'({pkt_words, {SH{1'b0}}});
        end else begin : g_hdr_narrow
            logic [PW+SH-1:0] full_bytes;
            assign full_bytes = {pkt_words, {SH{1'b0}}};
            assign hdr_bytes  = full_bytes[HL-1:0];
        end
    endgenerate

    assign busy        = (st != ST_IDLE);
    assign mem_rd_en   = (st == ST_RD);
    assign mem_rd_addr = src_q;
    assign out_valid   = (st == ST_HDR) || (st == ST_DATA);
    assign out_sop     = (st == ST_HDR);
    assign out_last    = (st == ST_DATA) && (pkt_left_q == PW'(1));
    assign out_data    = (st == ST_HDR) ? {hdr_bytes, dst_q} : data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            done       <= 1'b0;
            src_q      <= '0;
            dst_q      <= '0;
            rem_q      <= '0;
            pkt_left_q <= '0;
            data_q     <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (start) begin
                        done  <= 1'b0;
                        src_q <= word_align(cmd.src, SH);
                        dst_q <= word_align(cmd.dst, SH);
                        rem_q <= start_words;
                        if (start_words == '0) done <= 1'b1;
                        else                   st   <= ST_HDR;
                    end
                end
                ST_HDR: begin
                    if (out_ready) begin
                        pkt_left_q <= pkt_words;
                        st         <= ST_RD;
                    end
                end
                ST_RD: begin
                    src_q <= src_q + UBX_ADDR_W'(WB);
                    st    <= ST_CAP;
                end
                ST_CAP: begin
                    data_q <= mem_rd_data;
                    st     <= ST_DATA;
                end
                ST_DATA: begin
                    if (out_ready) begin
                        rem_q      <= rem_q - 1'b1;
                        dst_q      <= dst_q + UBX_ADDR_W'(WB);
                        pkt_left_q <= pkt_left_q - 1'b1;
                        if (pkt_left_q == PW'(1)) begin
                            if (rem_q == UBX_LEN_W'(1)) begin
                                st   <= ST_IDLE;
                                done <= 1'b1;
                            end else begin
                                st <= ST_HDR;
                            end
                        end else begin
                            st <= ST_RD;
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    AST_HOLD_BEAT: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data))) else $error("beat dropped"); // R10

    AST_ZERO_LEN_DONE: assert property (@(posedge clk) disable iff (rst)
        (start && start_words == '0) |=> (done && !busy)) else $error("zero length"); // R8

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> !busy) else $error("done while busy"); // R9

endmodule

// File: rtl/ubx_send_engine.sv
module ubx_send_engine
    import ubx_pkg::*;
#(
    parameter int DATA_W    = 64,
    parameter int PKT_BYTES = 64
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cmd_we,
    input  logic                  cmd_fire,
    input  logic [UBX_ADDR_W-1:0] cmd_addr,
    input  logic [UBX_LEN_W-1:0]  cmd_len,
    output logic                  busy,
    output logic                  done,
    output logic                  err,
    output logic                  mem_rd_en,
    output logic [UBX_ADDR_W-1:0] mem_rd_addr,
    input  logic [DATA_W-1:0]     mem_rd_data,
    output logic                  out_valid,
    input  logic                  out_ready,
    output logic                  out_sop,
    output logic                  out_last,
    output logic [DATA_W-1:0]     out_data
);

    localparam int PKT_WORDS = PKT_BYTES / (DATA_W / 8);

    logic      start;
    xfer_cmd_t cmd;

    ubx_cmd_port u_cmd (
        .clk      (clk),
        .rst      (rst),
        .cmd_we   (cmd_we),
        .cmd_fire (cmd_fire),
        .cmd_addr (cmd_addr),
        .cmd_len  (cmd_len),
        .busy     (busy),
        .start    (start),
        .cmd      (cmd),
        .err      (err)
    );

    ubx_mover #(.DATA_W(DATA_W), .PKT_BYTES(PKT_BYTES)) u_mover (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .cmd         (cmd),
        .busy        (busy),
        .done        (done),
        .mem_rd_en   (mem_rd_en),
        .mem_rd_addr (mem_rd_addr),
        .mem_rd_data (mem_rd_data),
        .out_valid   (out_valid),
        .out_ready   (out_ready),
        .out_sop     (out_sop),
        .out_last    (out_last),
        .out_data    (out_data)
    );

    logic [7:0] beats_q;
    always_ff @(posedge clk) begin
        if (rst) beats_q <= '0;
        else if (out_valid && out_ready) beats_q <= out_sop ? 8'd0 : beats_q + 8'd1;
    end

    AST_PKT_BOUND: assert property (@(posedge clk) disable iff (rst)
        beats_q <= 8'(PKT_WORDS)) else $error("packet too long"); // R4

    AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy) else $error("start while busy"); // R7

endmodule

// File: tb/tb_ubx_send_engine.sv
module tb_ubx_send_engine;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_we = 1'b0, cmd_fire = 1'b0;
    logic [31:0] cmd_addr = '0;
    logic [15:0] cmd_len = '0;
    logic        busy, done, err, mem_rd_en;
    logic [31:0] mem_rd_addr;
    logic [63:0] mem_rd_data = '0;
    logic        out_valid, out_sop, out_last;
    logic        out_ready = 1'b1;
    logic [63:0] out_data;

    int nchk = 0, nfail = 0, cyc = 0, nbeat = 0, hold_bad = 0;
    bit bp = 1'b0;
    logic [63:0] bdata [0:63];
    bit          bsop  [0:63];
    bit          blast [0:63];
    bit          stall_prev = 1'b0;
    logic [63:0] stall_data = '0;

    ubx_send_engine dut (.*);

    always #5 clk = ~clk;

    function automatic logic [63:0] mem_word(input logic [31:0] a);
        return {a, ~a};
    endfunction

    always @(posedge clk) begin
        if (mem_rd_en) mem_rd_data <= mem_word(mem_rd_addr);
    end

    always @(posedge clk) begin
        #1;
        cyc++;
        out_ready = bp ? (cyc % 3 != 0) : 1'b1;
        if (cyc > 100000) begin
            nfail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("%0d/%0d checks passed", nchk + 1 - nfail, nchk + 1);
            $finish;
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (stall_prev && !(out_valid && out_data == stall_data)) hold_bad++;
            stall_prev = out_valid && !out_ready;
            stall_data = out_data;
            if (out_valid && out_ready && nbeat < 64) begin
                bdata[nbeat] = out_data;
                bsop[nbeat]  = out_sop;
                blast[nbeat] = out_last;
                nbeat++;
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic access(input bit fire, input logic [31:0] a, input logic [15:0] l);
        @(posedge clk); #2;
        cmd_we = 1'b1; cmd_fire = fire; cmd_addr = a; cmd_len = l;
        @(posedge clk); #2;
        cmd_we = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (!busy) break;
        end
    endtask

    // R3 R4 R5: compare the recorded stream to one computed from the command
    task automatic compare_stream(input logic [31:0] dst, input logic [31:0] src,
                                  input logic [15:0] len);
        logic [31:0] d, s;
        int w, k, n;
        d = dst & ~32'h7; s = src & ~32'h7; w = len >> 3; k = 0;
        while (w > 0) begin
            n = (w > 8) ? 8 : w;
            check(k < nbeat && bsop[k] && bdata[k] == {32'(n * 8), d}, "R4/R5",
                  "header", bdata[k], {32'(n * 8), d});
            k++;
            for (int i = 0; i < n; i++) begin
                check(k < nbeat && !bsop[k] && bdata[k] == mem_word(s) &&
                      blast[k] == (i == n - 1), "R3/R4", "payload",
                      bdata[k], mem_word(s));
                k++; s += 8; d += 8;
            end
            w -= n;
        end
        check(nbeat == k, "R4", "beat count", 64'(nbeat), 64'(k));
    endtask

    typedef struct packed {
        logic [31:0] dst;
        logic [31:0] src;
        logic [15:0] len;
        logic        bp;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{dst: 32'h0000_1000, src: 32'h0000_2000, len: 16'd8,   bp: 1'b0},
        '{dst: 32'h0000_3008, src: 32'h0000_4000, len: 16'd64,  bp: 1'b1},
        '{dst: 32'h0000_5000, src: 32'h0000_6010, len: 16'd72,  bp: 1'b0},
        '{dst: 32'h0000_7000, src: 32'h0000_8000, len: 16'd200, bp: 1'b1},
        '{dst: 32'h0000_9003, src: 32'h0000_A005, len: 16'd20,  bp: 1'b0}
    };

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!busy && !done && !err && !out_valid && !mem_rd_en, "R1", "reset outputs",
              {busy, done, err, out_valid, mem_rd_en}, 0);
        @(posedge clk); #2 rst = 1'b0;
        @(negedge clk);
        check(!busy && !done && !err && !out_valid, "R1", "after reset",
              {busy, done, err, out_valid}, 0);

        // R6: fire without arm
        nbeat = 0;
        access(1'b1, 32'h100, 0);
        @(negedge clk);
        check(err && !busy, "R6", "orphan fire", {err, busy}, 2'b10);
        repeat (10) @(negedge clk);
        check(nbeat == 0, "R6", "orphan beats", 64'(nbeat), 0);
        access(1'b0, 32'h0, 16'd0);
        @(negedge clk);
        check(!err, "R6", "arm clears err", err, 0);

        // R8: zero length
        access(1'b1, 32'h40, 0);
        @(negedge clk);
        check(done && !busy, "R8", "zero length done", {done, busy}, 2'b10);
        repeat (10) @(negedge clk);
        check(nbeat == 0, "R8", "zero length beats", 64'(nbeat), 0);

        // R2 R9: start and finish timing for one word
        bp = 1'b0;
        access(1'b0, 32'h800, 16'd8);
        access(1'b1, 32'h900, 0);
        @(negedge clk);
        check(busy && !done, "R2/R9", "busy after fire", {busy, done}, 2'b10);
        for (int i = 0; i < 50; i++) begin
            if (out_valid && out_last) break;
            @(negedge clk);
        end
        check(out_last && !done && busy, "R9", "done before last accept",
              {out_last, done, busy}, 3'b101);
        @(negedge clk);
        check(done && !busy, "R9", "done after last accept", {done, busy}, 2'b10);

        // table of transfers: R2 R3 R4 R5 R10
        foreach (VECS[v]) begin
            bp = VECS[v].bp;
            nbeat = 0;
            access(1'b0, VECS[v].dst, VECS[v].len);
            access(1'b1, VECS[v].src, 0);
            wait_idle();
            check(done, "R9", "table done", done, 1);
            compare_stream(VECS[v].dst, VECS[v].src, VECS[v].len);
        end

        // R7: accesses while busy are refused
        bp = 1'b1;
        nbeat = 0;
        access(1'b0, 32'h100, 16'd64);
        access(1'b1, 32'h200, 0);
        access(1'b0, 32'hDE00, 16'd8);
        @(negedge clk);
        check(err && busy, "R7", "arm while busy", {err, busy}, 2'b11);
        access(1'b1, 32'hBE00, 0);
        wait_idle();
        compare_stream(32'h100, 32'h200, 16'd64);
        nbeat = 0;
        access(1'b1, 32'h300, 0);
        repeat (20) @(negedge clk);
        check(nbeat == 0 && !busy && err, "R7", "busy arm not kept",
              {32'(nbeat), 7'd0, busy, err}, 1);

        check(hold_bad == 0, "R10", "stalled beat held", 64'(hold_bad), 0);
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

endmodule